// File: doc/BRIEF.md
# Eight-Input Programmable Interrupt Controller

This block collects eight interrupt request lines, ranks them, and signals a processor through a single interrupt output. Software reaches it through a byte-wide port with two addresses: offset 0 carries setup and command words, and offset 1 carries the remaining setup words and, once setup is done, the mask. The processor answers the interrupt output with a one-cycle acknowledge pulse. The block replies on the next cycle with a vector byte and moves the winning request into the in-service set. In-service bits are later retired by end-of-interrupt commands, or at once in automatic mode.

After reset the controller does nothing until a setup sequence of two to four words completes. Bits of the first word decide how many words follow. That sequence fixes the vector base, edge or level sensing, single or cascaded use, the cascade word, and the mode bits that include automatic end-of-interrupt. Later words at offset 0 are commands. They retire in-service bits, rotate or set the priority order, toggle rotation in automatic mode, or choose which register a read of offset 0 returns.

Top module: `irq_ctrl`

## Requirements
- R1: A write to offset 0 with bit 4 set starts setup and clears the mask, the in-service set, pending requests and the priority order. Bit 0 of that word set means a fourth word follows, bit 1 set means single use (no cascade word), and bit 3 set selects level sensing. The following offset-1 writes supply the base word, then the cascade word (cascade use only, shown on `casc_cfg`), then the fourth word (bits 4:0 shown on `mode_cfg`, bit 1 = automatic end-of-interrupt). `single_mode` reflects bit 1.
- R2: Until setup completes, `int_out` stays low and no request is recorded. A line already high when setup ends raises nothing in edge mode.
- R3: On acknowledge with a request pending, `vec_out` = {base word bits 7:3, 3-bit input number}, and `vec_valid` is high on the following cycle only.
- R4: After setup, an offset-1 write loads the mask, where bit n = 1 blocks input n. A masked request still appears in the request register and is reported once unmasked. Reading offset 1 returns the mask.
- R5: With the default order, input 0 is highest and input 7 lowest. `int_out` is raised only for an unmasked request ranked above every in-service input.
- R6: Acknowledge clears the winner's request bit and sets its in-service bit. In edge mode, a line held high does not request again without a new rising edge.
- R7: A command word (bits 4:3 = 00) with bits 7:5 = 001 clears the highest-ranked in-service bit. Bits 7:5 = 011 clear only the in-service bit numbered by bits 2:0.
- R8: Command 101 retires the highest-ranked in-service bit and makes it lowest priority. Command 111 retires the bit named in bits 2:0 and makes that input lowest. Command 110 makes input bits 2:0 lowest without retiring anything. The input after the lowest ranks highest, with the order wrapping.
- R9: In automatic end-of-interrupt mode, acknowledge sets no in-service bit. Command 100 makes each acknowledged input lowest priority, and command 000 stops that.
- R10: In level mode, a request follows its line. After end-of-interrupt, a line still high interrupts again without a new edge.
- R11: A word with bits 4:3 = 01 and bit 1 = 1 selects what offset-0 reads return: bit 0 = 0 gives the request register, bit 0 = 1 the in-service register. Setup resets the choice to the request register.
- R12: An acknowledge with nothing pending returns base | 7 and changes neither the request nor the in-service register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 1 | Register offset (0 or 1) |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; `rd_data` updates on the next cycle |
| rd_data | output | 8 | Registered read data |
| irq_in | input | 8 | Request lines, bit n = input n |
| ack | input | 1 | One-cycle acknowledge from the processor |
| int_out | output | 1 | Registered interrupt output |
| vec_out | output | 8 | Vector byte returned after acknowledge |
| vec_valid | output | 1 | High for one cycle when `vec_out` is fresh |
| casc_cfg | output | 8 | Stored cascade word |
| single_mode | output | 1 | Single use selected in the first setup word |
| mode_cfg | output | 5 | Stored fourth setup word bits 4:0 |

## Verification
The bench checks setup sequences of each length. A sequencer that miscounts words would load the mask or mode bits from the wrong write, so the vector base or automatic end-of-interrupt would come out wrong. It tests nesting: a lower input arriving while a higher one is in service must stay silent, and a higher one must break through. A rank compare that ignores the in-service set, or ignores rotation, shows up as a wrong vector. It covers all three rotation commands and rotation in automatic mode, picking request pairs whose winner differs between fixed and rotated order. It also covers the held-line cases: a line high across setup, a line high after its end-of-interrupt in edge mode, and the same in level mode. A design that confused the two sensing modes would give a missing or extra interrupt there. A spurious acknowledge must return base | 7 and leave both registers untouched.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BASE,
    ST_CASC,
    ST_MODE,
    ST_RUN
  } setup_st_t;

  localparam logic [2:0] OP_AEOI_CLR = 3'b000;
  localparam logic [2:0] OP_NS_EOI   = 3'b001;
  localparam logic [2:0] OP_SP_EOI   = 3'b011;
  localparam logic [2:0] OP_AEOI_SET = 3'b100;
  localparam logic [2:0] OP_ROT_NS   = 3'b101;
  localparam logic [2:0] OP_SET_LOW  = 3'b110;
  localparam logic [2:0] OP_ROT_SP   = 3'b111;
endpackage

// File: rtl/irq_ctrl_cfg.sv
module irq_ctrl_cfg
  import irq_ctrl_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IW = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ready,
  output logic              setup_start,
  output logic              level_mode,
  output logic              single_mode,
  output logic              aeoi,
  output logic [DATA_W-IW-1:0] vec_base,
  output logic [DATA_W-1:0] casc_cfg,
  output logic [4:0]        mode_cfg,
  output logic [DATA_W-1:0] mask,
  output logic              rd_isr,
  output logic              op_vld,
  output logic [2:0]        op_code,
  output logic [IW-1:0]     op_lvl
);
  setup_st_t st;
  logic      need_mode;

  assign ready       = (st == ST_RUN);
  assign setup_start = wr_en && !addr && wr_data[4];
  assign op_vld      = wr_en && !addr && ready && (wr_data[4:3] == 2'b00);
  assign op_code     = wr_data[7:5];
  assign op_lvl      = wr_data[IW-1:0];
  assign aeoi        = mode_cfg[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      need_mode   <= 1'b0;
      single_mode <= 1'b0;
      level_mode  <= 1'b0;
      vec_base    <= '0;
      casc_cfg    <= '0;
      mode_cfg    <= '0;
      mask        <= '0;
      rd_isr      <= 1'b0;
    end else if (setup_start) begin
      st          <= ST_BASE;
      need_mode   <= wr_data[0];
      single_mode <= wr_data[1];
      level_mode  <= wr_data[3];
      mode_cfg    <= '0;
      mask        <= '0;
      rd_isr      <= 1'b0;
    end else if (wr_en && addr) begin
      case (st)
        ST_BASE: begin
          vec_base <= wr_data[DATA_W-1:IW];
          st <= !single_mode ? ST_CASC : (need_mode ? ST_MODE : ST_RUN);
        end
        ST_CASC: begin
          casc_cfg <= wr_data;
          st <= need_mode ? ST_MODE : ST_RUN;
        end
        ST_MODE: begin
          mode_cfg <= wr_data[4:0];
          st <= ST_RUN;
        end
        ST_RUN:  mask <= wr_data;
        default: ;
      endcase
    end else if (wr_en && ready && (wr_data[4:3] == 2'b01) && wr_data[1]) begin
      rd_isr <= wr_data[0];
    end
  end
endmodule

// File: rtl/irq_ctrl_req.sv
module irq_ctrl_req #(
  parameter int NUM = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           enable,
  input  logic           level_mode,
  input  logic [NUM-1:0] lines,
  input  logic [NUM-1:0] clr,
  output logic [NUM-1:0] irr
);
  logic [NUM-1:0] lines_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lines_q <= '0;
      irr     <= '0;
    end else begin
      lines_q <= lines;
      if (!enable)         irr <= '0;
      else if (level_mode) irr <= lines & ~clr;
      else                 irr <= (irr & ~clr) | (lines & ~lines_q);
    end
  end
endmodule

// File: rtl/irq_ctrl_prio.sv
module irq_ctrl_prio #(
  parameter int NUM = 8,
  localparam int IW = $clog2(NUM)
) (
  input  logic [NUM-1:0] vec,
  input  logic [IW-1:0]  low_pri,
  output logic           valid,
  output logic [IW-1:0]  idx
);
  logic [IW-1:0] cand;

  always_comb begin
    valid = |vec;
    idx   = '0;
    cand  = '0;
    for (int k = NUM - 1; k >= 0; k--) begin
      cand = low_pri + IW'(1) + IW'(k);
      if (vec[cand]) idx = cand;
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] irq_in,
  input  logic              ack,
  output logic              int_out,
  output logic [DATA_W-1:0] vec_out,
  output logic              vec_valid,
  output logic [DATA_W-1:0] casc_cfg,
  output logic              single_mode,
  output logic [4:0]        mode_cfg
);
  localparam int NUM = DATA_W;
  localparam int IW  = $clog2(NUM);
  localparam logic [NUM-1:0] ONE = NUM'(1);

  logic ready, setup_start, level_mode, aeoi, rd_isr, op_vld;
  logic [DATA_W-IW-1:0] vec_base;
  logic [NUM-1:0] mask, irr, isr, irr_clr, isr_clr, isr_set;
  logic [2:0]     op_code;
  logic [IW-1:0]  op_lvl, low_pri, lp_nxt, req_i, isr_i, req_rank, isr_rank;
  logic           req_v, isr_v, pend, take, rot_aeoi;

  irq_ctrl_cfg #(.DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .ready(ready), .setup_start(setup_start), .level_mode(level_mode),
    .single_mode(single_mode), .aeoi(aeoi), .vec_base(vec_base),
    .casc_cfg(casc_cfg), .mode_cfg(mode_cfg), .mask(mask), .rd_isr(rd_isr),
    .op_vld(op_vld), .op_code(op_code), .op_lvl(op_lvl)
  );

  irq_ctrl_req #(.NUM(NUM)) u_req (
    .clk(clk), .rst(rst), .enable(ready), .level_mode(level_mode),
    .lines(irq_in), .clr(irr_clr), .irr(irr)
  );

  irq_ctrl_prio #(.NUM(NUM)) u_pick_req (
    .vec(irr & ~mask), .low_pri(low_pri), .valid(req_v), .idx(req_i)
  );

  irq_ctrl_prio #(.NUM(NUM)) u_pick_isr (
    .vec(isr), .low_pri(low_pri), .valid(isr_v), .idx(isr_i)
  );

  // rank 0 is the input just after the lowest-priority one
  assign req_rank = req_i - low_pri - IW'(1);
  assign isr_rank = isr_i - low_pri - IW'(1);
  assign pend     = ready && req_v && (!isr_v || (req_rank < isr_rank));
  assign take     = ack && pend;
  assign irr_clr  = take ? (ONE << req_i) : '0;
  assign isr_set  = (take && !aeoi) ? (ONE << req_i) : '0;

  always_comb begin
    isr_clr = '0;
    lp_nxt  = low_pri;
    if (op_vld) begin
      case (op_code)
        OP_NS_EOI:  if (isr_v) isr_clr = ONE << isr_i;
        OP_SP_EOI:  isr_clr = ONE << op_lvl;
        OP_ROT_NS:  if (isr_v) begin
                      isr_clr = ONE << isr_i;
                      lp_nxt  = isr_i;
                    end
        OP_ROT_SP:  begin
                      isr_clr = ONE << op_lvl;
                      lp_nxt  = op_lvl;
                    end
        OP_SET_LOW: lp_nxt = op_lvl;
        default: ;
      endcase
    end
    if (take && aeoi && rot_aeoi) lp_nxt = req_i;
  end

  always_ff @(posedge clk) begin
    if (rst || setup_start) begin
      isr      <= '0;
      low_pri  <= '1;
      rot_aeoi <= 1'b0;
    end else begin
      isr     <= (isr & ~isr_clr) | isr_set;
      low_pri <= lp_nxt;
      if (op_vld && op_code == OP_AEOI_SET) rot_aeoi <= 1'b1;
      if (op_vld && op_code == OP_AEOI_CLR) rot_aeoi <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_out   <= 1'b0;
      vec_out   <= '0;
      vec_valid <= 1'b0;
      rd_data   <= '0;
    end else begin
      int_out   <= pend && !ack;
      vec_valid <= ack;
      if (ack) vec_out <= {vec_base, pend ? req_i : {IW{1'b1}}};
      if (rd_en) rd_data <= addr ? mask : (rd_isr ? isr : irr);
    end
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int DATA_W = 8,
  localparam int IW = $clog2(DATA_W)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ready,
  input logic                 int_out,
  input logic                 ack,
  input logic                 aeoi,
  input logic                 vec_valid,
  input logic [DATA_W-1:0]    vec_out,
  input logic [DATA_W-IW-1:0] vec_base,
  input logic [DATA_W-1:0]    isr
);
  // R2
  quiet_before_setup_chk: assert property (@(posedge clk) disable iff (rst)
    !ready |=> !int_out);

  // R3
  vec_follows_ack_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $past(ack));

  // R3
  vec_base_field_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> (vec_out[DATA_W-1:IW] == vec_base));

  // R6
  isr_one_new_bit_chk: assert property (@(posedge clk) disable iff (rst)
    ((isr & ~$past(isr)) != '0) |-> ($past(ack) && $countones(isr & ~$past(isr)) == 1));

  // R9
  auto_eoi_no_isr_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(ack) && $past(aeoi)) |-> ((isr & ~$past(isr)) == '0));
endmodule

bind irq_ctrl irq_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .ready(ready), .int_out(int_out), .ack(ack),
  .aeoi(aeoi), .vec_valid(vec_valid), .vec_out(vec_out),
  .vec_base(vec_base), .isr(isr)
);

// File: tb/irq_ctrl_tb.sv
`timescale 1ns/1ps
module irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, addr = 1'b0, rd_en = 1'b0, ack = 1'b0;
  logic [7:0] wr_data = '0, irq_in = '0;
  logic [7:0] rd_data, vec_out, casc_cfg;
  logic       int_out, vec_valid, single_mode;
  logic [4:0] mode_cfg;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  irq_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq_in(irq_in), .ack(ack),
    .int_out(int_out), .vec_out(vec_out), .vec_valid(vec_valid),
    .casc_cfg(casc_cfg), .single_mode(single_mode), .mode_cfg(mode_cfg)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic do_ack(output logic [7:0] v, output logic vv);
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    v = vec_out; vv = vec_valid;
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk);
    irq_in = v;
    settle();
  endtask

  task automatic ack_expect(input string req, input logic [7:0] exp);
    logic [7:0] v;
    logic vv;
    do_ack(v, vv);
    check(req, {7'd0, vv}, 8'h01);
    check(req, v, exp);
  endtask

  task automatic read_isr(input string req, input logic [7:0] exp);
    logic [7:0] d;
    wr(1'b0, 8'h0B);
    rd(1'b0, d);
    check(req, d, exp);
  endtask

  task automatic read_irr(input string req, input logic [7:0] exp);
    logic [7:0] d;
    wr(1'b0, 8'h0A);
    rd(1'b0, d);
    check(req, d, exp);
  endtask

  task automatic t_reset_and_setup();
    check("R2 reset int", {7'd0, int_out}, 8'h00);
    check("R3 reset vec_valid", {7'd0, vec_valid}, 8'h00);
    set_irq(8'h04);
    check("R2 no int before setup", {7'd0, int_out}, 8'h00);
    wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04);
    check("R2 no int mid setup", {7'd0, int_out}, 8'h00);
    wr(1'b1, 8'h01);
    settle();
    check("R1 cascade word", casc_cfg, 8'h04);
    check("R1 single flag", {7'd0, single_mode}, 8'h00);
    check("R1 mode word", {3'd0, mode_cfg}, 8'h01);
    check("R2 held line no edge", {7'd0, int_out}, 8'h00);
    set_irq(8'h00);
  endtask

  task automatic t_fixed_nesting();
    set_irq(8'h28);
    check("R5 int raised", {7'd0, int_out}, 8'h01);
    ack_expect("R3 R5 vec for 3", 8'h23);
    settle();
    check("R5 lower blocked by isr", {7'd0, int_out}, 8'h00);
    read_isr("R11 R6 isr after ack", 8'h08);
    read_irr("R11 R6 irr after ack", 8'h20);
    wr(1'b0, 8'h20); settle();
    check("R7 ns eoi releases 5", {7'd0, int_out}, 8'h01);
    ack_expect("R3 vec for 5", 8'h25);
    wr(1'b0, 8'h65); settle();
    read_isr("R7 specific eoi", 8'h00);
    check("R6 held line no reissue", {7'd0, int_out}, 8'h00);
    read_irr("R6 irr empty held", 8'h00);
    set_irq(8'h00);
    set_irq(8'h10);
    ack_expect("R5 vec 4", 8'h24);
    set_irq(8'h12);
    check("R5 higher nests", {7'd0, int_out}, 8'h01);
    ack_expect("R5 vec 1 nested", 8'h21);
    read_isr("R6 nested isr", 8'h12);
    wr(1'b0, 8'h20);
    read_isr("R7 ns eoi clears highest", 8'h10);
    wr(1'b0, 8'h20);
    read_isr("R7 second eoi", 8'h00);
    set_irq(8'h00);
    wr(1'b0, 8'h0A);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(1'b1, 8'h01);
    set_irq(8'h01);
    check("R4 masked no int", {7'd0, int_out}, 8'h00);
    rd(1'b0, d); check("R4 masked in irr", d, 8'h01);
    rd(1'b1, d); check("R4 mask readback", d, 8'h01);
    wr(1'b1, 8'h00); settle();
    check("R4 unmask raises", {7'd0, int_out}, 8'h01);
    ack_expect("R4 vec 0", 8'h20);
    wr(1'b0, 8'h20);
    set_irq(8'h00);
  endtask

  task automatic t_rotation();
    wr(1'b0, 8'hC2);
    set_irq(8'h12);
    ack_expect("R8 set lowest 2 picks 4", 8'h24);
    settle();
    check("R8 1 below 4", {7'd0, int_out}, 8'h00);
    wr(1'b0, 8'h20); settle();
    ack_expect("R8 then 1", 8'h21);
    wr(1'b0, 8'h20);
    set_irq(8'h00);
    wr(1'b0, 8'hC7);
    set_irq(8'h04);
    ack_expect("R8 vec 2", 8'h22);
    wr(1'b0, 8'hA0);
    read_isr("R8 rotate ns clears", 8'h00);
    set_irq(8'h0E);
    ack_expect("R8 after rotate 3 over 1", 8'h23);
    wr(1'b0, 8'h20);
    ack_expect("R8 then 1", 8'h21);
    wr(1'b0, 8'h20);
    set_irq(8'h00);
    set_irq(8'h01);
    ack_expect("R8 vec 0", 8'h20);
    wr(1'b0, 8'hE0);
    read_isr("R8 rotate specific clears", 8'h00);
    set_irq(8'h00);
    set_irq(8'h81);
    ack_expect("R8 7 over 0 after rotate", 8'h27);
    wr(1'b0, 8'h20);
    ack_expect("R8 then 0", 8'h20);
    wr(1'b0, 8'h20);
    set_irq(8'h00);
    wr(1'b0, 8'hC7);
  endtask

  task automatic t_auto_eoi();
    wr(1'b0, 8'h13); wr(1'b1, 8'h40); wr(1'b1, 8'h03);
    settle();
    check("R1 single mode", {7'd0, single_mode}, 8'h01);
    check("R1 mode word aeoi", {3'd0, mode_cfg}, 8'h03);
    set_irq(8'h40);
    ack_expect("R9 vec 6", 8'h46);
    read_isr("R9 no isr bit", 8'h00);
    wr(1'b0, 8'h80);
    set_irq(8'h00);
    set_irq(8'h40);
    ack_expect("R9 vec 6 again", 8'h46);
    set_irq(8'hA0);
    ack_expect("R9 rotated 7 over 5", 8'h47);
    wr(1'b0, 8'h00);
    ack_expect("R9 then 5", 8'h45);
    set_irq(8'h00);
    ack_expect("R12 spurious vec", 8'h47);
    read_isr("R12 isr unchanged", 8'h00);
    read_irr("R12 irr unchanged", 8'h00);
    check("R12 no int", {7'd0, int_out}, 8'h00);
  endtask

  task automatic t_level();
    wr(1'b0, 8'h1A); wr(1'b1, 8'h08);
    set_irq(8'h04);
    check("R10 level int", {7'd0, int_out}, 8'h01);
    ack_expect("R10 vec", 8'h0A);
    read_isr("R10 isr", 8'h04);
    wr(1'b0, 8'h20); settle();
    check("R10 reissue while high", {7'd0, int_out}, 8'h01);
    ack_expect("R10 vec again", 8'h0A);
    wr(1'b0, 8'h20);
    set_irq(8'h00);
    read_irr("R10 irr follows line", 8'h00);
    check("R10 no int after drop", {7'd0, int_out}, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_and_setup();
    t_fixed_nesting();
    t_mask();
    t_rotation();
    t_auto_eoi();
    t_level();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule